// File: doc/BRIEF.md
# Multi-channel prescaled PWM controller

This block generates a configurable number of pulse-width-modulated outputs from a small register file reached over a simple 32-bit write/read bus. Neighbouring channels are grouped in pairs. Each pair chooses one of two source-clock strobes and divides it by a power of two. Each channel then divides the pair's rate again by a linear factor and runs a period counter that shapes its output.

Every period opens with the active phase and falls to the inactive level once the programmed number of active counts has elapsed. A per-channel polarity bit decides whether the active level is high or low. A channel drives its output only when both its gate bit and its enable bit are set; otherwise the output rests at the inactive level. A write to any timing field of a channel restarts that channel's period at once, without waiting for the current period to end. Software loads the dividers and counts; the block does not compute them.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register reads zero, and every output is high. The polarity bit is clear after reset, so high is the inactive level.
- R2: Clock-configuration registers sit at byte offset 0x20 + 4*pair, where the pair index is channel/2. Bit 7 holds the source select and bits [3:0] hold M; all other bits read zero. The gate register is at 0x40 and the enable register at 0x80, with channel c at bit c. The channel control register is at 0x100 + 0x20*c and keeps bits [8:0]. The channel period register is at 0x104 + 0x20*c and keeps all 32 bits. Any other offset, including the slots of channels at or above NUM_CH, reads zero and ignores writes.
- R3: A channel runs when its gate and enable bits are both set. A running channel's period counter starts at 0 and advances by one on each tick. It wraps to 0 after reaching the value in period bits [31:16], so a period lasts that value plus one ticks. The output is active while the counter is below period bits [15:0].
- R4: An active count greater than the period field keeps the output active for the whole period. An active count of zero keeps the output inactive at all times.
- R5: With control bit 8 set, the active level is high; with it clear, the active level is low.
- R6: When a channel's gate bit or enable bit is clear, its output is the inverse of control bit 8 and its counters are held at zero. Re-enabling the channel starts a fresh period in the active phase.
- R7: Clock-configuration bit 7 set makes the pair count only the bus-clock strobe (bus_stb); bit 7 clear makes it count only the oscillator strobe (osc_stb). Strobes from the unselected source have no effect.
- R8: The pair divider passes one in every 2^M selected strobes. An M value above 8 acts as 8. Both channels of a pair share the divider.
- R9: Control bits [7:0] hold K. A channel ticks once for every K+1 outputs of its pair divider.
- R10: A write to a channel's control or period register, or to its pair's clock-configuration register, restarts that channel. The period counter and prescaler return to 0 on the write edge, and the pair divider also restarts on a clock-configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 12 | Byte offset for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| osc_stb | input | 1 | One-cycle enable strobe standing for the fixed oscillator clock |
| bus_stb | input | 1 | One-cycle enable strobe standing for the bus clock |
| pwm_out | output | NUM_CH | Channel outputs |

## Verification
Read data depends only on the current address, so it is sampled within the same cycle the address is applied. A register write takes effect on the clock edge that accepts it, and the outputs, which are combinational from the registers and counters, show the change at the next falling edge. A strobe held for one cycle moves a counter on that same edge, so its effect on an output is due one edge after the strobe is raised. The bench drives every input on a falling edge and samples at the following falling edge. It predicts each output from the number of strobes issued since the last restart, the divide factors 2^M and K+1, the period and the active count, without reference to the design's internal state.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   localparam int ADDR_W      = 12;
   localparam int DATA_W      = 32;
   localparam int CNT_W       = 16;
   localparam int PRE_W       = 8;
   localparam int EXP_W       = 4;
   localparam int DIV_EXP_MAX = 8;

   localparam int OFS_CLKCFG  = 'h020;
   localparam int OFS_GATE    = 'h040;
   localparam int OFS_EN      = 'h080;
   localparam int OFS_CH      = 'h100;
   localparam int CH_STRIDE   = 'h20;
   localparam int PER_OFS     = 'h4;

   typedef struct packed {
      logic             src_bus;
      logic [EXP_W-1:0] div_exp;
   } pair_cfg_t;

   typedef struct packed {
      logic             act_high;
      logic [PRE_W-1:0] pre_k;
      logic [CNT_W-1:0] ent_m1;
      logic [CNT_W-1:0] act_cnt;
   } chan_cfg_t;

   function automatic logic [ADDR_W-1:0] clkcfg_addr(input int p);
      return ADDR_W'(OFS_CLKCFG + 4 * p);
   endfunction

   function automatic logic [ADDR_W-1:0] ctl_addr(input int c);
      return ADDR_W'(OFS_CH + CH_STRIDE * c);
   endfunction

   function automatic logic [ADDR_W-1:0] per_addr(input int c);
      return ADDR_W'(OFS_CH + CH_STRIDE * c + PER_OFS);
   endfunction

endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 9,
   localparam int NPAIR = (NUM_CH + 1) / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output pair_cfg_t         pcfg [NPAIR],
   output chan_cfg_t         ccfg [NUM_CH],
   output logic [NUM_CH-1:0] gate_q,
   output logic [NUM_CH-1:0] en_q,
   output logic [NPAIR-1:0]  pair_wr,
   output logic [NUM_CH-1:0] chan_wr
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < NPAIR; p++) pcfg[p] <= '0;
         for (int c = 0; c < NUM_CH; c++) ccfg[c] <= '0;
         gate_q <= '0;
         en_q   <= '0;
      end else if (wr_en) begin
         for (int p = 0; p < NPAIR; p++) begin
            if (addr == clkcfg_addr(p)) begin
               pcfg[p].src_bus <= wdata[7];
               pcfg[p].div_exp <= wdata[EXP_W-1:0];
            end
         end
         for (int c = 0; c < NUM_CH; c++) begin
            if (addr == ctl_addr(c)) begin
               ccfg[c].act_high <= wdata[PRE_W];
               ccfg[c].pre_k    <= wdata[PRE_W-1:0];
            end
            if (addr == per_addr(c)) begin
               ccfg[c].ent_m1  <= wdata[2*CNT_W-1:CNT_W];
               ccfg[c].act_cnt <= wdata[CNT_W-1:0];
            end
         end
         if (addr == ADDR_W'(OFS_GATE)) gate_q <= wdata[NUM_CH-1:0];
         if (addr == ADDR_W'(OFS_EN))   en_q   <= wdata[NUM_CH-1:0];
      end
   end

   always_comb begin
      pair_wr = '0;
      chan_wr = '0;
      for (int p = 0; p < NPAIR; p++)
         pair_wr[p] = wr_en && (addr == clkcfg_addr(p));
      for (int c = 0; c < NUM_CH; c++)
         chan_wr[c] = wr_en && ((addr == ctl_addr(c)) || (addr == per_addr(c)));
   end

   always_comb begin
      rdata = '0;
      for (int p = 0; p < NPAIR; p++) begin
         if (addr == clkcfg_addr(p))
            rdata = DATA_W'({pcfg[p].src_bus, 3'b000, pcfg[p].div_exp});
      end
      for (int c = 0; c < NUM_CH; c++) begin
         if (addr == ctl_addr(c))
            rdata = DATA_W'({ccfg[c].act_high, ccfg[c].pre_k});
         if (addr == per_addr(c))
            rdata = {ccfg[c].ent_m1, ccfg[c].act_cnt};
      end
      if (addr == ADDR_W'(OFS_GATE)) rdata = DATA_W'(gate_q);
      if (addr == ADDR_W'(OFS_EN))   rdata = DATA_W'(en_q);
   end

endmodule

// File: rtl/pwm_pair_div.sv
module pwm_pair_div
   import pwm_bank_pkg::*;
#(
   parameter int EXP_MAX = DIV_EXP_MAX
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      osc_stb,
   input  logic      bus_stb,
   input  pair_cfg_t cfg,
   input  logic      restart,
   output logic      roll
);

   logic [EXP_MAX-1:0] div_cnt;
   logic [EXP_MAX-1:0] mask;
   logic [EXP_W-1:0]   exp_eff;
   logic               stb;

   assign stb     = cfg.src_bus ? bus_stb : osc_stb;
   assign exp_eff = (cfg.div_exp > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : cfg.div_exp;

   always_comb begin
      for (int i = 0; i < EXP_MAX; i++)
         mask[i] = (i < int'(exp_eff));
   end

   assign roll = stb && ((div_cnt & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n || restart) div_cnt <= '0;
      else if (stb)          div_cnt <= div_cnt + 1'b1;
   end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_bank_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             roll,
   input  chan_cfg_t        cfg,
   input  logic             run,
   input  logic             restart,
   output logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             out
);

   logic [PRE_W-1:0] pre;
   logic             pre_last;
   logic             active;

   assign pre_last = (pre == cfg.pre_k);
   assign tick     = run && roll && pre_last;

   always_ff @(posedge clk) begin
      if (!rst_n || !run || restart) begin
         pre <= '0;
         cnt <= '0;
      end else if (roll) begin
         if (pre_last) begin
            pre <= '0;
            cnt <= (cnt == cfg.ent_m1) ? '0 : cnt + 1'b1;
         end else begin
            pre <= pre + 1'b1;
         end
      end
   end

   assign active = run && (cnt < cfg.act_cnt);
   assign out    = active ? cfg.act_high : ~cfg.act_high;

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 9,
   localparam int NPAIR = (NUM_CH + 1) / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              osc_stb,
   input  logic              bus_stb,
   output logic [NUM_CH-1:0] pwm_out
);

   if (NUM_CH < 1 || NUM_CH > 16) begin : g_bad_num_ch
      $error("pwm_bank: NUM_CH must lie in 1..16");
   end
   if (DIV_EXP_MAX > (1 << EXP_W) - 1) begin : g_bad_exp
      $error("pwm_bank: divider exponent limit exceeds its field");
   end

   pair_cfg_t         pcfg [NPAIR];
   chan_cfg_t         ccfg [NUM_CH];
   logic [NUM_CH-1:0] gate_q;
   logic [NUM_CH-1:0] en_q;
   logic [NPAIR-1:0]  pair_wr;
   logic [NUM_CH-1:0] chan_wr;
   logic [NPAIR-1:0]  roll;

   logic [NUM_CH-1:0]       run_v;
   logic [NUM_CH-1:0]       pol_v;
   logic [NUM_CH-1:0]       tick_v;
   logic [NUM_CH-1:0]       rst_v;
   logic [NUM_CH*CNT_W-1:0] cnt_f;
   logic [NUM_CH*CNT_W-1:0] ent_f;
   logic [NUM_CH*CNT_W-1:0] act_f;

   pwm_bank_regs #(.NUM_CH(NUM_CH)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .pcfg    (pcfg),
      .ccfg    (ccfg),
      .gate_q  (gate_q),
      .en_q    (en_q),
      .pair_wr (pair_wr),
      .chan_wr (chan_wr)
   );

   for (genvar p = 0; p < NPAIR; p++) begin : g_pair
      pwm_pair_div #(.EXP_MAX(DIV_EXP_MAX)) u_div (
         .clk     (clk),
         .rst_n   (rst_n),
         .osc_stb (osc_stb),
         .bus_stb (bus_stb),
         .cfg     (pcfg[p]),
         .restart (pair_wr[p]),
         .roll    (roll[p])
      );
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      assign run_v[c] = gate_q[c] & en_q[c];
      assign rst_v[c] = chan_wr[c] | pair_wr[c/2];
      assign pol_v[c] = ccfg[c].act_high;
      assign ent_f[c*CNT_W +: CNT_W] = ccfg[c].ent_m1;
      assign act_f[c*CNT_W +: CNT_W] = ccfg[c].act_cnt;

      pwm_chan u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .roll    (roll[c/2]),
         .cfg     (ccfg[c]),
         .run     (run_v[c]),
         .restart (rst_v[c]),
         .tick    (tick_v[c]),
         .cnt     (cnt_f[c*CNT_W +: CNT_W]),
         .out     (pwm_out[c])
      );
   end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 9
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NUM_CH-1:0]       pwm_out,
   input logic [NUM_CH-1:0]       run_v,
   input logic [NUM_CH-1:0]       pol_v,
   input logic [NUM_CH-1:0]       tick_v,
   input logic [NUM_CH-1:0]       rst_v,
   input logic [NUM_CH*CNT_W-1:0] cnt_f,
   input logic [NUM_CH*CNT_W-1:0] ent_f,
   input logic [NUM_CH*CNT_W-1:0] act_f
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      // R6
      idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !run_v[c] |-> (pwm_out[c] == !pol_v[c]));

      // R4
      zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_f[c*CNT_W +: CNT_W] == '0) |-> (pwm_out[c] == !pol_v[c]));

      // R3
      count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (run_v[c] && !tick_v[c] && !rst_v[c]) |=> $stable(cnt_f[c*CNT_W +: CNT_W]));

      // R3
      count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         run_v[c] |-> (cnt_f[c*CNT_W +: CNT_W] <= ent_f[c*CNT_W +: CNT_W]));

      // R10
      restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rst_v[c] |=> (cnt_f[c*CNT_W +: CNT_W] == '0));
   end

endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pwm_out (pwm_out),
   .run_v   (run_v),
   .pol_v   (pol_v),
   .tick_v  (tick_v),
   .rst_v   (rst_v),
   .cnt_f   (cnt_f),
   .ent_f   (ent_f),
   .act_f   (act_f)
);

// File: tb/sim_pwm_bank.sv
module sim_pwm_bank;

   localparam int NCH = 9;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            reg_wr = 1'b0;
   logic [11:0]     reg_addr = '0;
   logic [31:0]     reg_wdata = '0;
   logic [31:0]     reg_rdata;
   logic            osc_stb = 1'b0;
   logic            bus_stb = 1'b0;
   logic [NCH-1:0]  pwm_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [31:0] gate_sh = '0;
   logic [31:0] en_sh   = '0;

   always #2 clk = ~clk;

   pwm_bank #(.NUM_CH(NCH)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .osc_stb   (osc_stb),
      .bus_stb   (bus_stb),
      .pwm_out   (pwm_out)
   );

   function automatic logic [11:0] a_clk(int c);  return 12'(32'h20 + 4 * (c / 2)); endfunction
   function automatic logic [11:0] a_ctl(int c);  return 12'(32'h100 + 32'h20 * c); endfunction
   function automatic logic [11:0] a_per(int c);  return 12'(32'h104 + 32'h20 * c); endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(bit use_bus);
      @(negedge clk);
      if (use_bus) bus_stb = 1'b1; else osc_stb = 1'b1;
      @(negedge clk);
      bus_stb = 1'b0; osc_stb = 1'b0;
   endtask

   task automatic setup(int c, logic [31:0] clkw, logic [31:0] ctlw, logic [31:0] perw);
      wr(a_ctl(c), ctlw);
      wr(a_per(c), perw);
      wr(a_clk(c), clkw);
      gate_sh = gate_sh | (32'd1 << c);
      wr(12'h040, gate_sh);
      en_sh = en_sh | (32'd1 << c);
      wr(12'h080, en_sh);
   endtask

   task automatic run_check(int c, int j0, int n, bit use_bus, int div,
                            int e, int a, bit pol, string tag);
      for (int j = 1; j <= n; j++) begin
         int ph;
         logic ex;
         pulse(use_bus);
         ph = ((j0 + j) / div) % (e + 1);
         ex = (ph < a) ? pol : ~pol;
         chk(tag, 32'(pwm_out[c]), 32'(ex));
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 outputs", 32'(pwm_out), 32'((1 << NCH) - 1));
      rd(12'h020, d); chk("R1 clkcfg", d, 0);
      rd(12'h040, d); chk("R1 gate", d, 0);
      rd(12'h080, d); chk("R1 enable", d, 0);
      rd(12'h100, d); chk("R1 ctl", d, 0);
      rd(12'h204, d); chk("R1 period", d, 0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      wr(12'h024, 32'hFFFF_FFFF); rd(12'h024, d); chk("R2 clkcfg mask", d, 32'h8F);
      wr(a_ctl(3), 32'hFFFF_FFFF); rd(a_ctl(3), d); chk("R2 ctl mask", d, 32'h1FF);
      wr(a_per(8), 32'h1234_5678); rd(a_per(8), d); chk("R2 period", d, 32'h1234_5678);
      wr(12'h040, 32'hFFFF_FFFF); rd(12'h040, d); chk("R2 gate", d, 32'h1FF);
      chk("R6 gated only", 32'(pwm_out[3]), 32'd0);
      wr(12'h044, 32'hAAAA_AAAA); rd(12'h044, d); chk("R2 unmapped 0x44", d, 0);
      rd(12'h010, d); chk("R2 unmapped 0x10", d, 0);
      wr(12'h108, 32'h5555_5555); rd(12'h108, d); chk("R2 unmapped 0x108", d, 0);
      wr(a_ctl(9), 32'h1FF); rd(a_ctl(9), d); chk("R2 beyond NUM_CH", d, 0);
      wr(12'h024, 0); wr(a_ctl(3), 0); wr(a_per(8), 0);
      wr(12'h040, 0); gate_sh = 0;
      chk("R1 back to idle", 32'(pwm_out), 32'((1 << NCH) - 1));
   endtask

   task automatic t_basic();
      setup(0, 32'h0, 32'h100, {16'd4, 16'd2});
      chk("R3 active at start", 32'(pwm_out[0]), 32'd1);
      run_check(0, 0, 12, 1'b0, 1, 4, 2, 1'b1, "R3 basic");
   endtask

   task automatic t_polarity();
      setup(2, 32'h0, 32'h000, {16'd3, 16'd1});
      chk("R5 active low start", 32'(pwm_out[2]), 32'd0);
      run_check(2, 0, 8, 1'b0, 1, 3, 1, 1'b0, "R5 active low");
   endtask

   task automatic t_edges();
      setup(4, 32'h0, 32'h100, {16'd2, 16'd5});
      run_check(4, 0, 6, 1'b0, 1, 2, 5, 1'b1, "R4 full duty");
      setup(5, 32'h0, 32'h100, {16'd2, 16'd0});
      chk("R4 zero duty start", 32'(pwm_out[5]), 32'd0);
      run_check(5, 0, 6, 1'b0, 1, 2, 0, 1'b1, "R4 zero duty");
   endtask

   task automatic t_src();
      setup(6, 32'h80, 32'h100, {16'd3, 16'd2});
      run_check(6, 0, 2, 1'b1, 1, 3, 2, 1'b1, "R7 bus source");
      for (int k = 0; k < 2; k++) begin
         pulse(1'b0);
         chk("R7 other source ignored", 32'(pwm_out[6]), 32'd0);
      end
      run_check(6, 2, 2, 1'b1, 1, 3, 2, 1'b1, "R7 bus source resumes");
   endtask

   task automatic t_prescale();
      setup(8, 32'h2, 32'h102, {16'd1, 16'd1});
      run_check(8, 0, 50, 1'b0, 12, 1, 1, 1'b1, "R9 prescale by K+1 with 2^M");
   endtask

   task automatic t_shared();
      setup(1, 32'h1, 32'h101, {16'd1, 16'd1});
      setup(0, 32'h1, 32'h100, {16'd1, 16'd1});
      run_check(0, 0, 8, 1'b0, 2, 1, 1, 1'b1, "R8 pair divider ch0");
      run_check(1, 8, 8, 1'b0, 4, 1, 1, 1'b1, "R8 shared divider ch1");
   endtask

   task automatic t_clamp();
      setup(0, 32'hF, 32'h100, {16'd1, 16'd1});
      run_check(0, 0, 260, 1'b0, 256, 1, 1, 1'b1, "R8 exponent clamp");
   endtask

   task automatic t_reload();
      setup(2, 32'h0, 32'h100, {16'd9, 16'd5});
      run_check(2, 0, 7, 1'b0, 1, 9, 5, 1'b1, "R3 long period");
      wr(a_per(2), {16'd3, 16'd2});
      chk("R10 period write restarts", 32'(pwm_out[2]), 32'd1);
      run_check(2, 0, 7, 1'b0, 1, 3, 2, 1'b1, "R10 new period");
      wr(a_ctl(2), 32'h100);
      chk("R10 ctl write restarts", 32'(pwm_out[2]), 32'd1);
      run_check(2, 0, 3, 1'b0, 1, 3, 2, 1'b1, "R10 after ctl write");
   endtask

   task automatic t_disable();
      en_sh = en_sh & ~32'd4;
      wr(12'h080, en_sh);
      chk("R6 disabled level", 32'(pwm_out[2]), 32'd0);
      for (int k = 0; k < 3; k++) pulse(1'b0);
      chk("R6 disabled holds", 32'(pwm_out[2]), 32'd0);
      en_sh = en_sh | 32'd4;
      wr(12'h080, en_sh);
      chk("R6 re-enable active phase", 32'(pwm_out[2]), 32'd1);
      gate_sh = gate_sh & ~32'd4;
      wr(12'h040, gate_sh);
      chk("R6 gate off level", 32'(pwm_out[2]), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_basic();
      t_polarity();
      t_edges();
      t_src();
      t_prescale();
      t_shared();
      t_clamp();
      t_reload();
      t_disable();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule